// File: doc/BRIEF.md
# Two-Operand Single-Cycle 16-bit Processor Core

This block is a small processor core that fetches one 16-bit instruction and retires it within each clock cycle. Each instruction names at most two registers. The first register is both a source and the destination. The core contains:

- an 8-bit program counter;
- a 256-word instruction store, which a test harness fills through a preload port while reset is held;
- eight general registers, where register 0 is an ordinary writable register;
- a separate 256-word data store;
- an ALU with a barrel shifter;
- a display register that holds the value of the last `put`.

A `halt` instruction freezes the core until the next reset. While halted, the core makes no register or memory writes, and the halt indicator stays high. Each `put` latches the first register into the display output. It also raises a strobe for one cycle, so that a monitor can collect the sequence of values the program printed. Branch and jump targets are absolute 8-bit instruction addresses. When a register value is used as an address, only its low 8 bits are taken.

Top module: `duo_core`

## Requirements

- R1: While `rst` is high at a clock edge, the program counter, `halted`, `disp_value` and `disp_valid` are cleared to zero. Execution starts at instruction address 0 on the first edge after `rst` falls.
- R2: The instruction fields are:
  - opcode: bits 15:12
  - A register: bits 11:9
  - B register: bits 8:6
  - shift amount: bits 4:1
  - immediate: bits 8:1
  - sub-select: bit 0

  Opcode 0001 writes A+B (sub-select 0) or A-B (sub-select 1) into A. Opcode 0011 writes A&B (0) or ~(A|B) (1) into A. All results are modulo 2^16.
- R3: Opcode 0100 shifts A by the 4-bit shift amount and writes the result back into A. Sub-select 0 shifts left and sub-select 1 shifts right, with zero fill in both directions.
- R4: Opcode 0010 adds the 8-bit immediate to A. With sub-select 1 the immediate is sign-extended; with sub-select 0 it is zero-extended. Register 0 is writable like any other register.
- R5: Opcode 1000 loads the PC with the immediate when A is nonzero, and opcode 1001 does so when A is zero. Otherwise the PC advances by one, so the instruction after the branch executes next.
- R6: Opcode 1100 loads the PC with the immediate. Opcode 1011 writes PC+1 into A and loads the PC with the immediate. Opcode 1010 loads the PC with the low 8 bits of A.
- R7: Opcode 0111 uses the low 8 bits of B as the data address. Sub-select 1 stores A to that address. Sub-select 0 loads A from that address.
- R8: Opcode 0000 copies A into `disp_value` and pulses `disp_valid` for exactly one cycle. In every other cycle `disp_value` holds its value.
- R9: Opcode 1111 sets `halted`, which stays set until reset. From then on the PC no longer changes and no `put`, register write or memory write takes effect.
- R10: Opcodes 0101, 0110, 1101 and 1110 change no register or memory and advance the PC by one.

## Ports

| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| rom_we | input | 1 | Write strobe for the instruction store preload |
| rom_addr | input | 8 | Preload word address |
| rom_wdata | input | 16 | Preload instruction word |
| disp_value | output | 16 | Value latched by the last `put` |
| disp_valid | output | 1 | One-cycle pulse after each `put` |
| halted | output | 1 | High once a `halt` has executed |

## Verification

The first program sweeps seven operand pairs through add, subtract, AND, NOR and both shift directions, using a different shift amount for each pair. The pairs include zero-extended small values, wrap-around at 0xFFFF and carry patterns, so swapped operands, wrong sub-select decoding and sign fill on a right shift each give a different printed sequence.

The second program takes each branch once in the taken direction and once in the not-taken direction. Every skipped path contains a `put`, so a branch resolved the wrong way adds or drops a value in the output. That program also:

- links and returns through a register;
- stores through an address register whose upper byte is nonzero and reads the word back through a clean address;
- passes through reserved opcodes;
- places a `put` right after `halt`, which must never appear in the output.

// File: rtl/duo_pkg.sv
package duo_pkg;

    localparam int unsigned WORD_W = 16;
    localparam int unsigned ADDR_W = 8;
    localparam int unsigned NUM_REGS = 8;
    localparam int unsigned IMM_W = 8;
    localparam int unsigned SHAMT_W = 4;

    localparam logic [3:0] OPC_PUT   = 4'h0;
    localparam logic [3:0] OPC_ARITH = 4'h1;
    localparam logic [3:0] OPC_ADDIM = 4'h2;
    localparam logic [3:0] OPC_LOGIC = 4'h3;
    localparam logic [3:0] OPC_SHIFT = 4'h4;
    localparam logic [3:0] OPC_MEM   = 4'h7;
    localparam logic [3:0] OPC_BNZ   = 4'h8;
    localparam logic [3:0] OPC_BZ    = 4'h9;
    localparam logic [3:0] OPC_JREG  = 4'hA;
    localparam logic [3:0] OPC_LINK  = 4'hB;
    localparam logic [3:0] OPC_JUMP  = 4'hC;
    localparam logic [3:0] OPC_HALT  = 4'hF;

    typedef enum logic [2:0] {
        ALU_ADD, ALU_SUB, ALU_AND, ALU_NOR, ALU_SHL, ALU_SHR
    } alu_op_e;

    typedef enum logic [1:0] {
        OPB_REG, OPB_SEXT, OPB_ZEXT
    } opb_sel_e;

    typedef enum logic [1:0] {
        WB_ALU, WB_LOAD, WB_LINK
    } wb_sel_e;

    typedef enum logic [2:0] {
        NPC_SEQ, NPC_IMM, NPC_REG, NPC_IF_NZ, NPC_IF_Z
    } npc_sel_e;

    typedef struct packed {
        alu_op_e  alu;
        opb_sel_e opb;
        wb_sel_e  wb;
        npc_sel_e npc;
        logic     reg_we;
        logic     mem_we;
        logic     put;
        logic     halt;
    } ctl_t;

endpackage

// File: rtl/duo_decode.sv
module duo_decode
    import duo_pkg::*;
(
    input  logic [3:0] opc,
    input  logic       subop,
    output ctl_t       ctl
);

    always_comb begin
        ctl = '0;
        ctl.alu = ALU_ADD;
        ctl.opb = OPB_REG;
        ctl.wb  = WB_ALU;
        ctl.npc = NPC_SEQ;
        case (opc)
            OPC_PUT:   ctl.put = 1'b1;
            OPC_ARITH: begin
                ctl.reg_we = 1'b1;
                ctl.alu    = subop ? ALU_SUB : ALU_ADD;
            end
            OPC_ADDIM: begin
                ctl.reg_we = 1'b1;
                ctl.opb    = subop ? OPB_SEXT : OPB_ZEXT;
            end
            OPC_LOGIC: begin
                ctl.reg_we = 1'b1;
                ctl.alu    = subop ? ALU_NOR : ALU_AND;
            end
            OPC_SHIFT: begin
                ctl.reg_we = 1'b1;
                ctl.alu    = subop ? ALU_SHR : ALU_SHL;
            end
            OPC_MEM: begin
                ctl.mem_we = subop;
                ctl.reg_we = ~subop;
                ctl.wb     = WB_LOAD;
            end
            OPC_BNZ:  ctl.npc = NPC_IF_NZ;
            OPC_BZ:   ctl.npc = NPC_IF_Z;
            OPC_JREG: ctl.npc = NPC_REG;
            OPC_LINK: begin
                ctl.reg_we = 1'b1;
                ctl.wb     = WB_LINK;
                ctl.npc    = NPC_IMM;
            end
            OPC_JUMP: ctl.npc = NPC_IMM;
            OPC_HALT: ctl.halt = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/duo_alu.sv
module duo_alu
    import duo_pkg::*;
#(
    parameter int unsigned DW = WORD_W,
    parameter int unsigned SW = SHAMT_W
) (
    input  alu_op_e         op,
    input  logic [DW-1:0]   a,
    input  logic [DW-1:0]   b,
    input  logic [SW-1:0]   shamt,
    output logic [DW-1:0]   y
);

    always_comb begin
        case (op)
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_NOR: y = ~(a | b);
            ALU_SHL: y = a << shamt;
            ALU_SHR: y = a >> shamt;
            default: y = a + b;
        endcase
    end

endmodule

// File: rtl/duo_regfile.sv
module duo_regfile
    import duo_pkg::*;
#(
    parameter int unsigned DW   = WORD_W,
    parameter int unsigned NREG = NUM_REGS,
    localparam int unsigned RSEL = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [RSEL-1:0] ra,
    input  logic [RSEL-1:0] rb,
    input  logic [RSEL-1:0] wa,
    input  logic            we,
    input  logic [DW-1:0]   wd,
    output logic [DW-1:0]   qa,
    output logic [DW-1:0]   qb
);

    logic [DW-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(NREG); i++) regs[i] <= '0;
        end else if (we) begin
            regs[wa] <= wd;
        end
    end

    assign qa = regs[ra];
    assign qb = regs[rb];

    // R2: a write lands in the addressed register and is visible next cycle
    p_write_lands_r2: assert property (@(posedge clk) disable iff (rst)
        we |=> regs[$past(wa)] == $past(wd));

endmodule

// File: rtl/duo_core.sv
module duo_core
    import duo_pkg::*;
#(
    parameter int unsigned DW   = WORD_W,
    parameter int unsigned AW   = ADDR_W,
    parameter int unsigned NREG = NUM_REGS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rom_we,
    input  logic [AW-1:0] rom_addr,
    input  logic [DW-1:0] rom_wdata,
    output logic [DW-1:0] disp_value,
    output logic          disp_valid,
    output logic          halted
);

    localparam int unsigned DEPTH = 1 << AW;
    localparam int unsigned RSEL  = $clog2(NREG);

    logic [DW-1:0] rom  [DEPTH];
    logic [DW-1:0] dmem [DEPTH];
    logic [AW-1:0] pc, pc_inc, pc_nxt, tgt;
    logic [DW-1:0] insn, va, vb, opb, alu_y, wd, sext, zext;
    logic [3:0]    opc;
    logic [RSEL-1:0] fa, fb;
    logic [SHAMT_W-1:0] shamt;
    logic [IMM_W-1:0] imm;
    logic          subop, running, reg_we, mem_we;
    ctl_t          ctl;
    logic          unused_bits;

    always_ff @(posedge clk) begin
        if (rom_we) rom[rom_addr] <= rom_wdata;
    end

    assign insn  = rom[pc];
    assign opc   = insn[15:12];
    assign fa    = insn[11:9];
    assign fb    = insn[8:6];
    assign shamt = insn[4:1];
    assign imm   = insn[8:1];
    assign subop = insn[0];
    assign unused_bits = insn[5];

    duo_decode i_dec (.opc(opc), .subop(subop), .ctl(ctl));

    assign running = ~halted;
    assign reg_we  = ctl.reg_we & running;
    assign mem_we  = ctl.mem_we & running;

    duo_regfile #(.DW(DW), .NREG(NREG)) i_rf (
        .clk(clk), .rst(rst), .ra(fa), .rb(fb), .wa(fa),
        .we(reg_we), .wd(wd), .qa(va), .qb(vb)
    );

    assign sext = {{(DW-IMM_W){imm[IMM_W-1]}}, imm};
    assign zext = {{(DW-IMM_W){1'b0}}, imm};

    always_comb begin
        case (ctl.opb)
            OPB_SEXT: opb = sext;
            OPB_ZEXT: opb = zext;
            default:  opb = vb;
        endcase
    end

    duo_alu #(.DW(DW), .SW(SHAMT_W)) i_alu (
        .op(ctl.alu), .a(va), .b(opb), .shamt(shamt), .y(alu_y)
    );

    assign pc_inc = pc + 1'b1;
    assign tgt    = imm[AW-1:0];

    always_comb begin
        case (ctl.wb)
            WB_LOAD: wd = dmem[vb[AW-1:0]];
            WB_LINK: wd = {{(DW-AW){1'b0}}, pc_inc};
            default: wd = alu_y;
        endcase
    end

    always_ff @(posedge clk) begin
        if (mem_we) dmem[vb[AW-1:0]] <= va;
    end

    always_comb begin
        case (ctl.npc)
            NPC_IMM:   pc_nxt = tgt;
            NPC_REG:   pc_nxt = va[AW-1:0];
            NPC_IF_NZ: pc_nxt = (va != '0) ? tgt : pc_inc;
            NPC_IF_Z:  pc_nxt = (va == '0) ? tgt : pc_inc;
            default:   pc_nxt = pc_inc;
        endcase
        if (ctl.halt) pc_nxt = pc;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc         <= '0;
            halted     <= 1'b0;
            disp_value <= '0;
            disp_valid <= 1'b0;
        end else begin
            disp_valid <= 1'b0;
            if (running) begin
                pc <= pc_nxt;
                if (ctl.halt) halted <= 1'b1;
                if (ctl.put) begin
                    disp_value <= va;
                    disp_valid <= 1'b1;
                end
            end
        end
    end

    // R9: halt is sticky until reset
    p_halt_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);

    // R9: a halted core no longer moves its program counter
    p_pc_frozen_r9: assert property (@(posedge clk) disable iff (rst)
        halted |=> $stable(pc));

    // R8: without an executed put the display holds and the strobe stays low
    p_disp_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !(ctl.put && running) |=> ($stable(disp_value) && !disp_valid));

    // R5: sequential flow advances the PC by exactly one
    p_pc_seq_r5: assert property (@(posedge clk) disable iff (rst)
        (running && !ctl.halt && ctl.npc == NPC_SEQ) |=> pc == AW'($past(pc) + 1'b1));

endmodule

// File: tb/test_duo_core.sv
`timescale 1ns/1ps
module test_duo_core;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rom_we = 1'b0;
    logic [7:0]  rom_addr = '0;
    logic [15:0] rom_wdata = '0;
    logic [15:0] disp_value;
    logic        disp_valid;
    logic        halted;

    always #2.5 clk = ~clk;

    duo_core i_duo_core (
        .clk(clk), .rst(rst), .rom_we(rom_we), .rom_addr(rom_addr),
        .rom_wdata(rom_wdata), .disp_value(disp_value),
        .disp_valid(disp_valid), .halted(halted)
    );

    int n_run = 0;
    int n_fail = 0;
    logic [15:0] img [256];
    int wp;
    logic [15:0] exp_v [64];
    string exp_t [64];
    int nexp;
    logic [15:0] got [64];
    int ngot;
    logic [15:0] last;
    int hold_err;

    always @(negedge clk) begin
        if (!rst) begin
            if (disp_valid) begin
                if (ngot < 64) got[ngot] = disp_value;
                ngot++;
                last = disp_value;
            end else if (disp_value !== last) begin
                hold_err++;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] expv);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, expv);
        end
    endtask

    function automatic logic [15:0] rw(input logic [3:0] op, input int a, input int b, input int sh, input bit sb);
        logic [2:0] fa = a[2:0];
        logic [2:0] fb = b[2:0];
        logic [3:0] s = sh[3:0];
        return {op, fa, fb, 1'b0, s, sb};
    endfunction

    function automatic logic [15:0] iw(input logic [3:0] op, input int a, input logic [7:0] imm, input bit sb);
        logic [2:0] fa = a[2:0];
        return {op, fa, imm, sb};
    endfunction

    task automatic emit(input logic [15:0] w);
        img[wp] = w;
        wp++;
    endtask

    task automatic expect_put(input logic [15:0] v, input string tag);
        exp_v[nexp] = v;
        exp_t[nexp] = tag;
        nexp++;
    endtask

    task automatic clear_image();
        for (int a = 0; a < 256; a++) img[a] = 16'hF000;
        wp = 0;
        nexp = 0;
    endtask

    task automatic load16(input int r, input logic [15:0] v);
        emit(rw(4'h1, r, r, 0, 1'b1));
        emit(iw(4'h2, r, v[15:8], 1'b0));
        emit(rw(4'h4, r, 0, 8, 1'b0));
        emit(iw(4'h2, r, v[7:0], 1'b0));
    endtask

    task automatic run_prog(input string name);
        int cyc;
        rst = 1'b1;
        @(negedge clk);
        for (int a = 0; a < 256; a++) begin
            rom_we = 1'b1;
            rom_addr = a[7:0];
            rom_wdata = img[a];
            @(negedge clk);
        end
        rom_we = 1'b0;
        @(negedge clk);
        check(disp_value == 16'h0, "R1 reset display", disp_value, 16'h0);
        check(disp_valid == 1'b0, "R1 reset strobe", {15'b0, disp_valid}, 16'h0);
        check(halted == 1'b0, "R1 reset halt", {15'b0, halted}, 16'h0);
        ngot = 0;
        last = 16'h0;
        hold_err = 0;
        rst = 1'b0;
        cyc = 0;
        while (!halted && cyc < 5000) begin
            @(negedge clk);
            cyc++;
        end
        if (!halted) check(1'b0, {"R9 watchdog ", name}, 16'(cyc), 16'h0);
        repeat (30) @(negedge clk);
        check(halted == 1'b1, {"R9 halted ", name}, {15'b0, halted}, 16'h1);
        check(ngot == nexp, {"R9 put count ", name}, 16'(ngot), 16'(nexp));
        for (int i = 0; i < nexp && i < ngot; i++)
            check(got[i] == exp_v[i], {exp_t[i], " ", name}, got[i], exp_v[i]);
        check(hold_err == 0, {"R8 display hold ", name}, 16'(hold_err), 16'h0);
    endtask

    initial begin
        logic [15:0] a, b, r;
        int s;
        // Program A: ALU and shift sweep (R2, R3)
        clear_image();
        for (int i = 0; i < 7; i++) begin
            if (i == 6) begin
                a = 16'hFFFF;
                b = 16'h0001;
            end else begin
                a = 16'(i * 16'h3A7D + 16'h0F0F);
                b = 16'((i * 16'hC351) ^ 16'h00FF);
            end
            s = (i * 3 + 1) % 16;
            load16(1, a);
            load16(2, b);
            for (int k = 0; k < 4; k++) begin
                emit(rw(4'h1, 3, 3, 0, 1'b1));
                emit(rw(4'h1, 3, 1, 0, 1'b0));
                case (k)
                    0: begin emit(rw(4'h1, 3, 2, 0, 1'b0)); r = a + b;    end
                    1: begin emit(rw(4'h1, 3, 2, 0, 1'b1)); r = a - b;    end
                    2: begin emit(rw(4'h3, 3, 2, 0, 1'b0)); r = a & b;    end
                    default: begin emit(rw(4'h3, 3, 2, 0, 1'b1)); r = ~(a | b); end
                endcase
                emit(rw(4'h0, 3, 0, 0, 1'b0));
                expect_put(r, "R2 alu");
            end
            for (int k = 0; k < 2; k++) begin
                emit(rw(4'h1, 3, 3, 0, 1'b1));
                emit(rw(4'h1, 3, 1, 0, 1'b0));
                emit(rw(4'h4, 3, 0, s, k[0]));
                emit(rw(4'h0, 3, 0, 0, 1'b0));
                r = (k == 0) ? (a << s) : (a >> s);
                expect_put(r, "R3 shift");
            end
        end
        emit(16'hF000);
        run_prog("progA");

        // Program B: immediates, branches, jumps, memory, reserved, halt
        clear_image();
        emit(rw(4'h1, 0, 0, 0, 1'b1));
        emit(iw(4'h2, 0, 8'hFF, 1'b1));
        emit(rw(4'h0, 0, 0, 0, 1'b0));
        expect_put(16'hFFFF, "R4 sign-extended r0");
        emit(rw(4'h1, 1, 1, 0, 1'b1));
        emit(iw(4'h2, 1, 8'hFF, 1'b0));
        emit(rw(4'h0, 1, 0, 0, 1'b0));
        expect_put(16'h00FF, "R4 zero-extended");
        emit(iw(4'h9, 1, 8'h40, 1'b0));
        emit(iw(4'h8, 1, 8'h20, 1'b0));
        emit(rw(4'h0, 1, 0, 0, 1'b0));
        wp = 8'h20;
        emit(rw(4'h1, 2, 2, 0, 1'b1));
        emit(iw(4'h9, 2, 8'h30, 1'b0));
        emit(rw(4'h0, 1, 0, 0, 1'b0));
        wp = 8'h30;
        emit(iw(4'h8, 2, 8'h40, 1'b0));
        emit(iw(4'h2, 2, 8'h11, 1'b0));
        emit(rw(4'h0, 2, 0, 0, 1'b0));
        expect_put(16'h0011, "R5 branch path");
        emit(iw(4'hB, 3, 8'h50, 1'b0));
        emit(rw(4'h0, 3, 0, 0, 1'b0));
        emit(iw(4'hC, 0, 8'h60, 1'b0));
        expect_put(16'h0034, "R6 link value at target");
        expect_put(16'h0034, "R6 return via register");
        wp = 8'h40;
        emit(rw(4'h0, 0, 0, 0, 1'b0));
        emit(16'hF000);
        wp = 8'h50;
        emit(rw(4'h0, 3, 0, 0, 1'b0));
        emit(rw(4'hA, 3, 0, 0, 1'b0));
        wp = 8'h60;
        load16(4, 16'h0112);
        load16(5, 16'hBEEF);
        emit(rw(4'h7, 5, 4, 0, 1'b1));
        emit(rw(4'h1, 5, 5, 0, 1'b1));
        emit(rw(4'h1, 6, 6, 0, 1'b1));
        emit(iw(4'h2, 6, 8'h12, 1'b0));
        emit(rw(4'h7, 7, 6, 0, 1'b0));
        emit(rw(4'h0, 7, 0, 0, 1'b0));
        expect_put(16'hBEEF, "R7 load via clean address");
        emit(rw(4'h7, 5, 4, 0, 1'b0));
        emit(rw(4'h0, 5, 0, 0, 1'b0));
        expect_put(16'hBEEF, "R7 load via high-byte address");
        emit(16'h5E01);
        emit(16'hDE00);
        emit(rw(4'h0, 7, 0, 0, 1'b0));
        expect_put(16'hBEEF, "R10 reserved opcodes");
        emit(16'hF000);
        emit(rw(4'h0, 0, 0, 0, 1'b0));
        run_prog("progB");

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #1000000;
        n_run++;
        n_fail++;
        $display("FAIL R9 global watchdog: got %h expected %h", 16'h1, 16'h0);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule